// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block pairs two eight-input interrupt controllers. The upper one (the slave) collects lines 8 to 15 and presents its own request on input 2 of the lower one (the master). The master drives the single request output to the processor. Each controller is programmed through a shared byte-wide register bus. Every controller has a command port and a data port. The command port takes the initialization start word, specific end-of-interrupt commands and the status-select command. The data port takes the remaining initialization words and, after that, the interrupt mask.

The processor answers a raised request with a one-cycle acknowledge strobe. One cycle later the block returns the vector byte together with a valid pulse. The winning request moves from the request register (IRR) to the in-service register (ISR). While a source is in service, sources of equal or lower priority cannot interrupt it. When the master's winner is the cascade input, the vector and the in-service update come from the slave.

Each controller runs a small initialization state machine with four states. `ST_READY` is normal operation. `ST_BASE` waits for the vector-base word. `ST_CASC` waits for the cascade word. `ST_MODE` waits for the mode word. A start word moves the machine from any state to `ST_BASE`. From `ST_BASE`, a data write moves to `ST_CASC`, or to `ST_MODE` when the start word chose single mode and asked for a mode word, or to `ST_READY` when it chose single mode and asked for none. From `ST_CASC`, a data write moves to `ST_MODE` if a mode word was asked for, and to `ST_READY` otherwise. From `ST_MODE`, a data write moves to `ST_READY`.

Top module: `pic_pair`

## Requirements
- R1: After reset both masks read 0xFF, both IRR and ISR are zero, command-port reads return IRR, `int_req` is low and `ack_vec_vld` is low.
- R2: A command write with bit 4 set starts initialization. Its bit 1 skips the cascade word and its bit 0 requests a mode word. The following data writes are taken as base, then cascade, then mode, and none of them changes the mask. The start word clears ISR and returns the status select to IRR.
- R3: The vector byte is base bits 7:3 followed by the 3-bit input number. Bits 2:0 of the written base are ignored.
- R4: Outside initialization, a data write loads the mask and a data read returns it. A mask bit of 1 blocks its input from raising `int_req`, but the request is still recorded in IRR.
- R5: An IRR bit is set on a rising edge of its line. It clears when the line is low or when that input is acknowledged.
- R6: Priority is fixed with input 0 highest. `int_req` is high only when an unmasked IRR bit has strictly higher priority than every ISR bit.
- R7: After an acknowledge strobe, `ack_vec_vld` is high for exactly the next cycle with the vector on `ack_vec`. The winning bit is set in ISR and cleared from IRR.
- R8: The slave's request drives master input 2 as a level, and `irq_in[2]` is ignored. The master uses the slave only when its cascade word has bit 2 set and the slave's cascade word holds identity 2. In that case, acknowledging input 2 returns the slave's vector (slave base + n) and sets both master ISR bit 2 and slave ISR bit n.
- R9: A command write with bits 7:5 = 011 and bits 4:3 = 00 is a specific EOI. It clears ISR bit n (bits 2:0) in the addressed controller only.
- R10: A command write of 0x0B makes later command-port reads return ISR, and 0x0A makes them return IRR. The bit pattern is bit 4 = 0, bit 3 = 1, bit 1 = 1, and bit 0 selects ISR.
- R11: An acknowledge arriving while `int_req` is low returns the master base + 7 and changes no ISR bit.
- R12: An acknowledge and a specific EOI to the same controller in one cycle both take effect. The winner is chosen against the ISR as it was before the EOI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; 0-7 master, 8-15 slave, bit 2 unused |
| reg_sel_hi | input | 1 | Register access target: 0 master, 1 slave |
| reg_port | input | 1 | 0 command/status port, 1 mask/data port |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed port |
| int_req | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle interrupt acknowledge |
| ack_vec | output | 8 | Vector returned for the last acknowledge |
| ack_vec_vld | output | 1 | High the cycle after an acknowledge |

## Verification
An acknowledge and a specific EOI can hit the same controller in one cycle. The bench provokes this by raising the acknowledge strobe in the same cycle as a 0x60+n command write. At that moment ISR holds a low-priority bit and a higher-priority request is pending. The result is judged by the returned vector, which must be the pending input's vector, and by reading ISR afterwards, which must show only the newly served bit.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIC_LINES  = 8;
    localparam int PIC_IDX_W  = $clog2(PIC_LINES);
    localparam int PIC_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_READY,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_e;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  isr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Walk from highest priority (0) down; an in-service bit blocks itself and below.
    always_comb begin : walk
        logic blocked;
        blocked = 1'b0;
        hit     = 1'b0;
        idx     = '0;
        for (int i = 0; i < N; i++) begin
            if (isr[i]) begin
                blocked = 1'b1;
            end
            if (!blocked && !hit && req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
    import pic_pkg::*;
#(
    parameter logic [PIC_LINES-1:0] LEVEL_LINES = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIC_LINES-1:0]  lines,
    input  logic                  cmd_wr,
    input  logic                  data_wr,
    input  logic [PIC_BYTE_W-1:0] wdata,
    input  logic                  ack,
    output logic                  int_o,
    output logic [PIC_IDX_W-1:0]  win_o,
    output logic [PIC_BYTE_W-1:0] vec_o,
    output logic [PIC_LINES-1:0]  mask_o,
    output logic [PIC_LINES-1:0]  irr_o,
    output logic [PIC_LINES-1:0]  isr_o,
    output logic [PIC_BYTE_W-1:0] casc_o,
    output logic                  stat_isr_o
);
    localparam logic [PIC_IDX_W-1:0] SPUR_IDX = PIC_IDX_W'(PIC_LINES - 1);

    init_st_e               st_q, st_d;
    logic                   single_q, need_mode_q, stat_isr_q;
    logic [PIC_BYTE_W-1:0]  base_q, casc_q;
    logic [PIC_LINES-1:0]   mask_q, isr_q, isr_d, irr;
    logic [PIC_LINES-1:0]   set_bits, eoi_bits;
    logic                   is_start, is_seoi, is_stat, hit, take;
    logic [PIC_IDX_W-1:0]   win;

    // Command decode
    assign is_start = cmd_wr && wdata[4];
    assign is_seoi  = cmd_wr && (st_q == ST_READY) && (wdata[7:5] == 3'b011) && (wdata[4:3] == 2'b00);
    assign is_stat  = cmd_wr && (st_q == ST_READY) && !wdata[7] && (wdata[4:3] == 2'b01) && wdata[1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (is_start) begin
            st_d = ST_BASE;
        end else if (data_wr) begin
            unique case (st_q)
                ST_READY: st_d = ST_READY;
                ST_BASE:  st_d = single_q ? (need_mode_q ? ST_MODE : ST_READY) : ST_CASC;
                ST_CASC:  st_d = need_mode_q ? ST_MODE : ST_READY;
                ST_MODE:  st_d = ST_READY;
            endcase
        end
    end

    // Priority resolution
    pic_prio #(.N(PIC_LINES)) u_prio (
        .req (irr & ~mask_q),
        .isr (isr_q),
        .hit (hit),
        .idx (win)
    );

    assign take = ack && hit;

    always_comb begin
        set_bits = '0;
        eoi_bits = '0;
        if (take)    set_bits[win]        = 1'b1;
        if (is_seoi) eoi_bits[wdata[2:0]] = 1'b1;
        isr_d = is_start ? '0 : ((isr_q & ~eoi_bits) | set_bits);
    end

    // Configuration and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_q    <= 1'b0;
            need_mode_q <= 1'b0;
            stat_isr_q  <= 1'b0;
            base_q      <= '0;
            casc_q      <= '0;
            mask_q      <= '1;
            isr_q       <= '0;
        end else begin
            isr_q <= isr_d;
            if (is_start) begin
                single_q    <= wdata[1];
                need_mode_q <= wdata[0];
                stat_isr_q  <= 1'b0;
            end else if (is_stat) begin
                stat_isr_q  <= wdata[0];
            end
            if (data_wr) begin
                unique case (st_q)
                    ST_READY: mask_q <= wdata;
                    ST_BASE:  base_q <= {wdata[PIC_BYTE_W-1:PIC_IDX_W], PIC_IDX_W'(0)};
                    ST_CASC:  casc_q <= wdata;
                    ST_MODE:  ;
                endcase
            end
        end
    end

    // Request capture: edge-latched lines or plain level lines
    for (genvar g = 0; g < PIC_LINES; g++) begin : g_irr
        if (LEVEL_LINES[g]) begin : g_level
            assign irr[g] = lines[g];
        end else begin : g_edge
            logic prev_q, req_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    req_q  <= 1'b0;
                end else begin
                    prev_q <= lines[g];
                    if (!lines[g])                                  req_q <= 1'b0;
                    else if (!prev_q)                               req_q <= 1'b1;
                    else if (take && (win == PIC_IDX_W'(g)))        req_q <= 1'b0;
                end
            end
            assign irr[g] = req_q;
        end
    end

    assign int_o      = hit;
    assign win_o      = win;
    assign vec_o      = {base_q[PIC_BYTE_W-1:PIC_IDX_W], hit ? win : SPUR_IDX};
    assign mask_o     = mask_q;
    assign irr_o      = irr;
    assign isr_o      = isr_q;
    assign casc_o     = casc_q;
    assign stat_isr_o = stat_isr_q;
endmodule

// File: rtl/pic_pair.sv
module pic_pair
    import pic_pkg::*;
#(
    parameter int CASC_IN = 2,
    localparam int IRQS = 2 * PIC_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IRQS-1:0]       irq_in,
    input  logic                  reg_sel_hi,
    input  logic                  reg_port,
    input  logic                  reg_wr,
    input  logic [PIC_BYTE_W-1:0] reg_wdata,
    output logic [PIC_BYTE_W-1:0] reg_rdata,
    output logic                  int_req,
    input  logic                  ack,
    output logic [PIC_BYTE_W-1:0] ack_vec,
    output logic                  ack_vec_vld
);
    localparam logic [PIC_LINES-1:0] M_LEVEL = PIC_LINES'(1) << CASC_IN;

    logic [PIC_LINES-1:0]  m_lines;
    logic                  m_int, s_int, m_stat, s_stat, casc_hit, s_ack;
    logic [PIC_IDX_W-1:0]  m_win, s_win;
    logic [PIC_BYTE_W-1:0] m_vec, s_vec, m_casc, s_casc, vec_q;
    logic [PIC_LINES-1:0]  m_mask, s_mask, m_irr, s_irr, m_isr, s_isr;
    logic                  vld_q;
    logic                  unused_bits;

    always_comb begin
        m_lines          = irq_in[PIC_LINES-1:0];
        m_lines[CASC_IN] = s_int;
    end

    assign casc_hit = m_int && (m_win == PIC_IDX_W'(CASC_IN)) && m_casc[CASC_IN]
                      && (s_casc[PIC_IDX_W-1:0] == PIC_IDX_W'(CASC_IN));
    assign s_ack    = ack && casc_hit;

    pic_unit #(.LEVEL_LINES(M_LEVEL)) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines      (m_lines),
        .cmd_wr     (reg_wr && !reg_sel_hi && !reg_port),
        .data_wr    (reg_wr && !reg_sel_hi && reg_port),
        .wdata      (reg_wdata),
        .ack        (ack),
        .int_o      (m_int),
        .win_o      (m_win),
        .vec_o      (m_vec),
        .mask_o     (m_mask),
        .irr_o      (m_irr),
        .isr_o      (m_isr),
        .casc_o     (m_casc),
        .stat_isr_o (m_stat)
    );

    pic_unit #(.LEVEL_LINES('0)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines      (irq_in[IRQS-1:PIC_LINES]),
        .cmd_wr     (reg_wr && reg_sel_hi && !reg_port),
        .data_wr    (reg_wr && reg_sel_hi && reg_port),
        .wdata      (reg_wdata),
        .ack        (s_ack),
        .int_o      (s_int),
        .win_o      (s_win),
        .vec_o      (s_vec),
        .mask_o     (s_mask),
        .irr_o      (s_irr),
        .isr_o      (s_isr),
        .casc_o     (s_casc),
        .stat_isr_o (s_stat)
    );

    // Vector register: captured on the acknowledge edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            vec_q <= '0;
        end else begin
            vld_q <= ack;
            if (ack) vec_q <= casc_hit ? s_vec : m_vec;
        end
    end

    // Register read mux
    always_comb begin
        if (reg_sel_hi) reg_rdata = reg_port ? s_mask : (s_stat ? s_isr : s_irr);
        else            reg_rdata = reg_port ? m_mask : (m_stat ? m_isr : m_irr);
    end

    assign unused_bits = ^{irq_in[CASC_IN], m_casc, s_casc, s_win};
    assign int_req     = m_int;
    assign ack_vec     = vec_q;
    assign ack_vec_vld = vld_q;
endmodule

// File: rtl/pic_pair_chk.sv
module pic_pair_chk
    import pic_pkg::*;
#(
    parameter int CASC_IN = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic                 reg_port,
    input logic                 ack,
    input logic                 ack_vec_vld,
    input logic                 int_req,
    input logic [PIC_LINES-1:0] m_irr,
    input logic [PIC_LINES-1:0] m_mask,
    input logic [PIC_LINES-1:0] s_mask,
    input logic [PIC_LINES-1:0] m_isr,
    input logic [PIC_LINES-1:0] s_isr
);
    AST_VLD_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_vec_vld);                                                  // R7
    AST_VLD_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !ack_vec_vld);                                                // R7
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_port) |=> ($stable(m_mask) && $stable(s_mask)));       // R4
    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((m_irr & ~m_mask) != '0));                                // R6
    AST_ISR_GROWS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> (((m_isr & ~$past(m_isr)) == '0) && ((s_isr & ~$past(s_isr)) == '0))); // R7
    AST_SLAVE_MARKS_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_isr & ~$past(s_isr)) != '0) |-> m_isr[CASC_IN]);                   // R8
endmodule

bind pic_pair pic_pair_chk #(.CASC_IN(CASC_IN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_port    (reg_port),
    .ack         (ack),
    .ack_vec_vld (ack_vec_vld),
    .int_req     (int_req),
    .m_irr       (m_irr),
    .m_mask      (m_mask),
    .s_mask      (s_mask),
    .m_isr       (m_isr),
    .s_isr       (s_isr)
);

// File: tb/pic_pair_tb_top.sv
`timescale 1ns/1ps
module pic_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        reg_sel_hi = 1'b0, reg_port = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        int_req;
    logic        ack = 1'b0;
    logic [7:0]  ack_vec;
    logic        ack_vec_vld;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pic_pair dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_sel_hi(reg_sel_hi), .reg_port(reg_port), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_req(int_req),
        .ack(ack), .ack_vec(ack_vec), .ack_vec_vld(ack_vec_vld)
    );

    // {line[3:0], expected vector[7:0]} with master base 0x20, slave base 0x28
    localparam logic [11:0] VEC_TBL [12] = '{
        {4'd0, 8'h20}, {4'd1, 8'h21}, {4'd3, 8'h23}, {4'd4, 8'h24},
        {4'd5, 8'h25}, {4'd6, 8'h26}, {4'd7, 8'h27}, {4'd8, 8'h28},
        {4'd9, 8'h29}, {4'd11, 8'h2B}, {4'd13, 8'h2D}, {4'd15, 8'h2F}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic hi, input logic port, input logic [7:0] d);
        @(negedge clk);
        reg_sel_hi = hi; reg_port = port; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic hi, input logic port, output logic [7:0] v);
        @(negedge clk);
        reg_sel_hi = hi; reg_port = port;
        #1 v = reg_rdata;
    endtask

    task automatic line(input int n, input logic v);
        @(negedge clk);
        irq_in[n] = v;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic vl);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        v  = ack_vec;
        vl = ack_vec_vld;
    endtask

    task automatic full_init();
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog requirement=all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic       vl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, 1, v); chk("R1 master mask", v, 8'hFF);
        rd(1, 1, v); chk("R1 slave mask", v, 8'hFF);
        rd(0, 0, v); chk("R1 master IRR", v, 8'h00);
        rd(1, 0, v); chk("R1 slave IRR", v, 8'h00);
        chk("R1 int_req", {7'd0, int_req}, 8'h00);
        chk("R1 ack_vec_vld", {7'd0, ack_vec_vld}, 8'h00);

        // R5/R4/R8: masked request recorded, irq_in[2] ignored
        line(3, 1'b1); line(2, 1'b1);
        rd(0, 0, v); chk("R5 R8 IRR records edge, line 2 ignored", v, 8'h08);
        chk("R4 masked no int", {7'd0, int_req}, 8'h00);
        line(3, 1'b0); line(2, 1'b0);
        rd(0, 0, v); chk("R5 IRR clears on low line", v, 8'h00);

        // R2/R3: short initialization (single, no mode word), base low bits ignored
        wr(0, 0, 8'h0B);
        wr(0, 0, 8'h12);
        rd(0, 1, v); chk("R2 mask untouched by start", v, 8'hFF);
        wr(0, 1, 8'h47);
        wr(0, 1, 8'hF0);
        rd(0, 1, v); chk("R2 mask after short init", v, 8'hF0);
        line(3, 1'b1);
        @(negedge clk);
        chk("R4 unmasked raises int", {7'd0, int_req}, 8'h01);
        do_ack(v, vl);
        chk("R3 vector from base 0x47", v, 8'h43);
        chk("R7 vld", {7'd0, vl}, 8'h01);
        wr(0, 0, 8'h63);
        line(3, 1'b0);

        // R2: full initialization; start word resets status select to IRR
        wr(0, 0, 8'h0B);
        full_init();
        rd(0, 1, v); chk("R2 mask kept through init", v, 8'hF0);
        line(3, 1'b1);
        rd(0, 0, v); chk("R2 status back to IRR", v, 8'h08);
        line(3, 1'b0);
        wr(0, 1, 8'h00); wr(1, 1, 8'h00);

        // Table walk: R7 vector per line, R8 through cascade for 8..15
        for (int i = 0; i < 12; i++) begin
            int n;
            n = int'(VEC_TBL[i][11:8]);
            line(n, 1'b1);
            @(negedge clk);
            chk("R6 int on single request", {7'd0, int_req}, 8'h01);
            do_ack(v, vl);
            chk("R7 table vector", v, VEC_TBL[i][7:0]);
            line(n, 1'b0);
            if (n >= 8) begin
                wr(1, 0, 8'h60 | 8'(n - 8));
                wr(0, 0, 8'h62);
            end else begin
                wr(0, 0, 8'h60 | 8'(n));
            end
            @(negedge clk);
            chk("R9 quiet after EOI", {7'd0, int_req}, 8'h00);
        end

        // R6/R10: fixed priority and nesting
        @(negedge clk);
        irq_in[6] = 1'b1; irq_in[1] = 1'b1;
        do_ack(v, vl);
        chk("R6 input 1 beats 6", v, 8'h21);
        @(negedge clk);
        chk("R6 lower blocked by ISR", {7'd0, int_req}, 8'h00);
        wr(0, 0, 8'h0B);
        rd(0, 0, v); chk("R10 ISR read", v, 8'h02);
        wr(0, 0, 8'h0A);
        rd(0, 0, v); chk("R10 IRR read", v, 8'h40);
        line(0, 1'b1);
        @(negedge clk);
        chk("R6 higher preempts", {7'd0, int_req}, 8'h01);
        do_ack(v, vl);
        chk("R6 nested vector", v, 8'h20);
        wr(0, 0, 8'h60); wr(0, 0, 8'h61);
        @(negedge clk);
        chk("R9 EOI releases pending 6", {7'd0, int_req}, 8'h01);
        do_ack(v, vl);
        chk("R6 vector 6", v, 8'h26);
        wr(0, 0, 8'h66);
        line(0, 1'b0); line(1, 1'b0); line(6, 1'b0);

        // R8/R9: cascade in-service bookkeeping and EOI order
        line(10, 1'b1);
        do_ack(v, vl);
        chk("R8 slave vector", v, 8'h2A);
        wr(0, 0, 8'h0B); wr(1, 0, 8'h0B);
        rd(0, 0, v); chk("R8 master ISR bit 2", v, 8'h04);
        rd(1, 0, v); chk("R8 slave ISR bit 2", v, 8'h04);
        line(10, 1'b0);
        wr(1, 0, 8'h62);
        rd(1, 0, v); chk("R9 slave EOI", v, 8'h00);
        rd(0, 0, v); chk("R9 master untouched", v, 8'h04);
        wr(0, 0, 8'h62);
        rd(0, 0, v); chk("R9 master EOI", v, 8'h00);

        // R4: mask then unmask
        wr(0, 1, 8'h08);
        line(3, 1'b1);
        @(negedge clk);
        chk("R4 masked line", {7'd0, int_req}, 8'h00);
        wr(0, 1, 8'h00);
        @(negedge clk);
        chk("R4 unmasked line", {7'd0, int_req}, 8'h01);
        do_ack(v, vl);
        chk("R4 vector", v, 8'h23);
        wr(0, 0, 8'h63);
        line(3, 1'b0);

        // R11: spurious acknowledge
        line(4, 1'b1);
        line(4, 1'b0);
        @(negedge clk);
        chk("R11 int dropped", {7'd0, int_req}, 8'h00);
        do_ack(v, vl);
        chk("R11 spurious vector", v, 8'h27);
        rd(0, 0, v); chk("R11 ISR unchanged", v, 8'h00);

        // R12: acknowledge and EOI in the same cycle
        line(5, 1'b1);
        do_ack(v, vl);
        chk("R12 setup vector", v, 8'h25);
        line(1, 1'b1);
        @(negedge clk);
        chk("R12 pending higher", {7'd0, int_req}, 8'h01);
        @(negedge clk);
        ack = 1'b1;
        reg_sel_hi = 1'b0; reg_port = 1'b0; reg_wdata = 8'h65; reg_wr = 1'b1;
        @(negedge clk);
        ack = 1'b0; reg_wr = 1'b0;
        chk("R12 vector", ack_vec, 8'h21);
        rd(0, 0, v); chk("R12 ISR after merge", v, 8'h02);
        wr(0, 0, 8'h61);
        line(1, 1'b0); line(5, 1'b0);

        // R8: irq_in[2] ignored after init
        wr(0, 0, 8'h0A);
        line(2, 1'b1);
        @(negedge clk);
        chk("R8 line 2 no int", {7'd0, int_req}, 8'h00);
        rd(0, 0, v); chk("R8 line 2 not in IRR", v, 8'h00);
        line(2, 1'b0);

        finish_run();
    end
endmodule